// File: doc/BRIEF.md
# Periodic Interrupt Modulus Counter

This block counts 1/100 s ticks in an 8-bit register and raises an interrupt each time the count reaches a modulus set by software. When that happens the count returns to zero and counting goes on. Software sees the block at one register address. A write to that address sets the modulus, and a read from it returns the running count.

A zero modulus turns interrupts off. The counter still runs, and it stops at its top value of 255, which is 2.55 s at the tick rate. A call-received strobe clears both the modulus and the count. The counter then rises from zero, so a later read gives the time since the call in 1/100 s units, up to the saturation value. Only one command acts in a clock cycle, and the order is: call strobe first, then register write, then tick.

Top module: `pic_modcnt`

## Requirements
- R1: After reset the count reads 255, the modulus is zero and the interrupt output is low.
- R2: While the modulus is nonzero and no command is present, each clock with the tick input high raises the count by one. A clock without a tick leaves the count unchanged.
- R3: With a modulus M, a tick that would take the count to M sets the count to 0 instead and drives the interrupt high for exactly one clock, so interrupts come every M ticks. This includes M = 1 and M = 255.
- R4: Writing a nonzero value loads it as the modulus and restarts the count at 0. The read port shows the count, never the modulus.
- R5: Writing zero stops interrupts at once. The counter keeps advancing on ticks, and a tick in the same cycle as the write is still counted.
- R6: With a zero modulus the count stops at 255 and holds there through any number of further ticks.
- R7: The call strobe sets modulus and count to zero. Afterwards the count equals the number of ticks since the strobe, up to 255.
- R8: A call strobe takes priority over a write in the same cycle. A nonzero write takes priority over a tick in the same cycle.
- R9: The interrupt is never high while the modulus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-clock strobe every 1/100 s |
| call_i | input | 1 | Call-received strobe, one clock |
| wr_en_i | input | 1 | Write strobe for the modulus register |
| wr_data_i | input | 8 | Modulus value to write |
| rd_data_o | output | 8 | Current count, the read value of the register |
| irq_o | output | 1 | Interrupt pulse, one clock wide |

## Verification
The modulus cannot be read back, so a wrong modulus shows up only in the timing of interrupts. A modulus that is off by one moves the first interrupt by one tick, and that tick is also when the count drops to zero. A zero modulus that was not stored properly shows as an interrupt after a stop, or as a count that passes an old modulus without wrapping. A wrong saturation or priority shows on the read port in the clock after the stimulus. The saturation case needs 255 ticks before the first wrong value can appear.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int PIC_CNT_W = 8;

    // Command seen by the register and counter in a cycle, highest priority first
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_CALL = 2'd1,
        CMD_LOAD = 2'd2,
        CMD_STOP = 2'd3
    } pic_cmd_e;

    typedef struct packed {
        pic_cmd_e cmd;
        logic     tick;
    } pic_req_t;

    function automatic pic_cmd_e pic_decode(input logic call, input logic wr, input logic nonzero);
        pic_cmd_e c;
        if (call)
            c = CMD_CALL;
        else if (wr && nonzero)
            c = CMD_LOAD;
        else if (wr)
            c = CMD_STOP;
        else
            c = CMD_NONE;
        return c;
    endfunction

endpackage

// File: rtl/pic_mod_reg.sv
module pic_mod_reg
    import pic_pkg::*;
#(
    parameter int CNT_W = PIC_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  pic_req_t         req,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] mod_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mod_q <= '0;
        end else begin
            unique case (req.cmd)
                CMD_CALL: mod_q <= '0;
                CMD_STOP: mod_q <= '0;
                CMD_LOAD: mod_q <= wr_data;
                default:  mod_q <= mod_q;
            endcase
        end
    end

endmodule

// File: rtl/pic_count_core.sv
module pic_count_core
    import pic_pkg::*;
#(
    parameter int CNT_W = PIC_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  pic_req_t         req,
    input  logic [CNT_W-1:0] mod_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CNT_W:0]   inc_wide;
    logic [CNT_W-1:0] cnt_d;
    logic             mod_live;

    assign inc_wide = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign mod_live = (mod_q != '0) && (req.cmd == CMD_NONE);
    assign wrap     = req.tick && mod_live && (inc_wide == {1'b0, mod_q});

    always_comb begin
        cnt_d = cnt_q;
        if (req.cmd == CMD_CALL || req.cmd == CMD_LOAD) begin
            cnt_d = '0;
        end else if (req.tick) begin
            if (wrap)
                cnt_d = '0;
            else if (mod_live)
                cnt_d = inc_wide[CNT_W-1:0];
            else if (cnt_q != CNT_TOP)
                cnt_d = inc_wide[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= CNT_TOP;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/pic_irq_out.sv
module pic_irq_out (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    output logic irq_q
);

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= wrap;
    end

endmodule

// File: rtl/pic_modcnt.sv
module pic_modcnt
    import pic_pkg::*;
#(
    parameter int CNT_W = PIC_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             call_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] rd_data_o,
    output logic             irq_o
);

    pic_req_t         req;
    logic [CNT_W-1:0] mod_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign req.cmd  = pic_decode(call_i, wr_en_i, wr_data_i != '0);
    assign req.tick = tick_i;

    pic_mod_reg #(.CNT_W(CNT_W)) u_mod (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .wr_data (wr_data_i),
        .mod_q   (mod_q)
    );

    pic_count_core #(.CNT_W(CNT_W)) u_core (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .mod_q (mod_q),
        .cnt_q (cnt_q),
        .wrap  (wrap)
    );

    pic_irq_out u_irq (
        .clk   (clk),
        .rst   (rst),
        .wrap  (wrap),
        .irq_q (irq_o)
    );

    assign rd_data_o = cnt_q;

endmodule

// File: rtl/pic_modcnt_chk.sv
module pic_modcnt_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_i,
    input logic             call_i,
    input logic             wr_en_i,
    input logic [CNT_W-1:0] wr_data_i,
    input logic [CNT_W-1:0] cnt,
    input logic             irq,
    input logic [CNT_W-1:0] modv
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    AST_IRQ_NEEDS_MOD: assert property (@(posedge clk) disable iff (rst)
        irq |-> (modv != '0)); // R9

    AST_IRQ_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cnt == '0)); // R3

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !call_i && !wr_en_i) |=> ($stable(cnt) && !irq)); // R2

    AST_CALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        call_i |=> (cnt == '0 && modv == '0 && !irq)); // R7

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_data_i != '0 && !call_i) |=> (cnt == '0 && modv == $past(wr_data_i))); // R4

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (modv == '0 && cnt == TOP && !call_i && !(wr_en_i && wr_data_i != '0)) |=> (cnt == TOP)); // R6

    AST_STOP_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_data_i == '0 && !call_i) |=> !irq); // R5

endmodule

bind pic_modcnt pic_modcnt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .call_i    (call_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cnt       (rd_data_o),
    .irq       (irq_o),
    .modv      (mod_q)
);

// File: tb/pic_modcnt_tb.sv
module pic_modcnt_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 21;

    typedef struct packed {
        logic       call;
        logic       wr;
        logic [7:0] wdata;
        logic       tick;
        logic [7:0] exp_cnt;
        logic       exp_irq;
    } vec_t;

    // call, wr, wdata, tick, expected count, expected irq
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 8'd3, 1'b0, 8'd0, 1'b0},   // R4 load 3
        '{1'b0, 1'b0, 8'd0, 1'b1, 8'd1, 1'b0},   // R2
        '{1'b0, 1'b0, 8'd0, 1'b0, 8'd1, 1'b0},   // R2 no tick
        '{1'b0, 1'b0, 8'd0, 1'b1, 8'd2, 1'b0},   // R2
        '{1'b0, 1'b0, 8'd0, 1'b1, 8'd0, 1'b1},   // R3 wrap
        '{1'b0, 1'b0, 8'd0, 1'b0, 8'd0, 1'b0},   // R3 single pulse
        '{1'b0, 1'b0, 8'd0, 1'b1, 8'd1, 1'b0},   // R3
        '{1'b0, 1'b0, 8'd0, 1'b1, 8'd2, 1'b0},   // R3
        '{1'b0, 1'b0, 8'd0, 1'b1, 8'd0, 1'b1},   // R3 second period
        '{1'b0, 1'b1, 8'd0, 1'b1, 8'd1, 1'b0},   // R5 stop with tick
        '{1'b0, 1'b0, 8'd0, 1'b1, 8'd2, 1'b0},   // R5
        '{1'b0, 1'b0, 8'd0, 1'b1, 8'd3, 1'b0},   // R5 passes old modulus
        '{1'b1, 1'b1, 8'd5, 1'b1, 8'd0, 1'b0},   // R8 call wins
        '{1'b0, 1'b0, 8'd0, 1'b1, 8'd1, 1'b0},   // R7 modulus zero now
        '{1'b0, 1'b0, 8'd0, 1'b1, 8'd2, 1'b0},   // R7
        '{1'b0, 1'b1, 8'd2, 1'b1, 8'd0, 1'b0},   // R8 write beats tick
        '{1'b0, 1'b0, 8'd0, 1'b1, 8'd1, 1'b0},   // R2
        '{1'b0, 1'b0, 8'd0, 1'b1, 8'd0, 1'b1},   // R3 modulus 2
        '{1'b0, 1'b1, 8'd1, 1'b0, 8'd0, 1'b0},   // R4 load 1
        '{1'b0, 1'b0, 8'd0, 1'b1, 8'd0, 1'b1},   // R3 modulus 1
        '{1'b0, 1'b0, 8'd0, 1'b1, 8'd0, 1'b1}    // R3 modulus 1 again
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       tick_i, call_i, wr_en_i;
    logic [7:0] wr_data_i;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_modcnt u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .call_i    (call_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [7:0] cnt_exp, input logic irq_exp);
        n_run++;
        if (rd_data_o !== cnt_exp || irq_o !== irq_exp) begin
            n_fail++;
            $display("FAIL %s: count=%0d irq=%0b expected count=%0d irq=%0b",
                     req, rd_data_o, irq_o, cnt_exp, irq_exp);
        end
    endtask

    // drive for one clock, starting and ending at a falling edge
    task automatic cyc(input logic c, input logic w, input logic [7:0] d, input logic t);
        call_i = c; wr_en_i = w; wr_data_i = d; tick_i = t;
        @(negedge clk);
        call_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0; tick_i = 1'b0;
    endtask

    initial begin
        int irq_seen;
        rst = 1'b1;
        call_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0; tick_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", 8'd255, 1'b0);

        // R1: with modulus zero after reset, ticks leave the saturated count
        cyc(1'b0, 1'b0, 8'd0, 1'b1);
        check("R1", 8'd255, 1'b0);

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].call, VEC[i].wr, VEC[i].wdata, VEC[i].tick);
            check($sformatf("vector %0d", i), VEC[i].exp_cnt, VEC[i].exp_irq);
        end

        // R7: delay since call, with idle cycles interleaved
        cyc(1'b1, 1'b0, 8'd0, 1'b0);
        for (int i = 0; i < 37; i++) begin
            cyc(1'b0, 1'b0, 8'd0, 1'b1);
            cyc(1'b0, 1'b0, 8'd0, 1'b0);
        end
        check("R7", 8'd37, 1'b0);

        // R6 and R9: run past saturation with modulus zero
        irq_seen = 0;
        for (int i = 0; i < 300; i++) begin
            cyc(1'b0, 1'b0, 8'd0, 1'b1);
            if (irq_o) irq_seen++;
        end
        check("R6", 8'd255, 1'b0);
        n_run++;
        if (irq_seen != 0) begin
            n_fail++;
            $display("FAIL R9: irq pulses=%0d expected 0", irq_seen);
        end
        cyc(1'b0, 1'b0, 8'd0, 1'b1);
        check("R6", 8'd255, 1'b0);

        // R3: largest modulus
        cyc(1'b0, 1'b1, 8'd255, 1'b0);
        for (int i = 0; i < 254; i++) cyc(1'b0, 1'b0, 8'd0, 1'b1);
        check("R3", 8'd254, 1'b0);
        cyc(1'b0, 1'b0, 8'd0, 1'b1);
        check("R3", 8'd0, 1'b1);

        // R5: stop in the middle of a period, no irq after
        cyc(1'b0, 1'b1, 8'd4, 1'b0);
        cyc(1'b0, 1'b0, 8'd0, 1'b1);
        cyc(1'b0, 1'b1, 8'd0, 1'b0);
        check("R5", 8'd1, 1'b0);
        irq_seen = 0;
        for (int i = 0; i < 6; i++) begin
            cyc(1'b0, 1'b0, 8'd0, 1'b1);
            if (irq_o) irq_seen++;
        end
        n_run++;
        if (irq_seen != 0 || rd_data_o != 8'd7) begin
            n_fail++;
            $display("FAIL R5: count=%0d irq pulses=%0d expected count=7 irq pulses=0",
                     rd_data_o, irq_seen);
        end

        // R1: reset in the middle of operation
        cyc(1'b0, 1'b1, 8'd9, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", 8'd255, 1'b0);

        done = 1'b1;
    end

    initial begin
        int cycles = 0;
        while (!done && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: timeout after %0d cycles, expected completion", cycles);
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule